// File: doc/BRIEF.md
# Montgomery Ladder Scalar Sequencer

This block drives the point-level schedule of an elliptic-curve scalar multiplication k·P. A `run` pulse presents an unsigned scalar. The sequencer locates the leading one of that scalar. It then sends a stream of commands to an external point-arithmetic unit. Each command carries an operation code, two source slots and a destination slot. The external unit holds the points, does the field arithmetic and converts between affine and projective coordinates. The sequencer only decides what happens to which slot, and when.

After a single load command, the schedule is one doubling to seed the second working point. After that, every remaining scalar bit costs exactly one addition followed by one doubling. The value of the bit only chooses which slot each of those two commands writes. The command count therefore depends only on the bit length of the scalar, never on the values of its lower bits. A final export command moves the first working point out in affine form. `valid` then rises and stays high until the next accepted `run`. A zero scalar sends no commands at all: it reports the point at infinity through `identity`.

Top module: `ladder_seq`

## Requirements
- R1: After reset, `valid`, `identity` and `cmdValid` are all 0.
- R2: A `run` with scalar 0 raises `valid` and `identity` in the cycle after the accepting edge, and no command is issued.
- R3: A scalar of 1 issues exactly two commands, load (code 0) and then export (code 3). The exported value is P.
- R4: Before the loop, the base point is loaded into slot 1 (op 0) and doubled from slot 1 into slot 2 (op 2, code 2). After every doubling, slot 2 holds slot 1 plus P.
- R5: For a scalar bit of 1, the addition (op 1) reads slots 1 and 2 and writes slot 1. The following doubling reads and writes slot 2.
- R6: For a scalar bit of 0, the addition reads slots 1 and 2 and writes slot 2. The following doubling reads and writes slot 1. The export (op 3, reading slot 1) yields k·P.
- R7: A scalar whose leading one sits at bit index L (L ≥ 1) produces exactly L additions and L+1 doublings. Bits are taken from index L-1 down to 0.
- R8: `cmdValid` is only high while `cmdReady` is high. After a command is accepted, no further command is issued until `cmdDone` has been seen.
- R9: A `run` pulse or a changed `scalar` while a multiplication is in progress has no effect on the command stream or the result. `valid` stays low throughout the multiplication.
- R10: `valid` remains high after completion until the next `run`. An accepted `run` with a nonzero scalar drops it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start pulse, sampled only while idle |
| scalar | input | KW | Scalar k, captured with `run` |
| cmdReady | input | 1 | Point unit can accept a command |
| cmdDone | input | 1 | Point unit finished the outstanding command |
| cmdValid | output | 1 | Command handed over on this edge |
| cmdOp | output | 2 | 0 load, 1 add, 2 double, 3 export |
| cmdSrcA | output | SLOT_W | First source slot |
| cmdSrcB | output | SLOT_W | Second source slot (add only) |
| cmdDst | output | SLOT_W | Destination slot |
| valid | output | 1 | Result available, held until next run |
| identity | output | 1 | Result is the point at infinity |

## Verification
The zero-scalar result is due one cycle after the `run` edge. The bench samples `valid` and `identity` at the very next falling edge, with no polling. Commands are combinational on `cmdReady`, so the bench sets `cmdReady` just after a falling edge and samples `cmdValid` one time step later. It then treats a high sample as accepted on the coming rising edge. It answers with `cmdDone` after 1 to 3 cycles. `valid` is due on the edge that consumes the final `cmdDone`, and the bench checks the exported value and the command counts at the falling edge that follows. All 2^KW scalars are swept, some with a disturbing `run` in mid-flight.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_ADD    = 2'd1,
    OP_DBL    = 2'd2,
    OP_EXPORT = 2'd3
  } ladder_op_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_SEED,
    PH_ADD,
    PH_DBL,
    PH_OUT
  } ladder_phase_t;

  // strobes from control to the scalar datapath
  typedef struct packed {
    logic capture;
    logic step;
  } scan_strobe_t;

endpackage

// File: rtl/ladder_scan.sv
module ladder_scan
  import ladder_pkg::*;
#(
  parameter int KW = 8,
  localparam int IDX_W = (KW > 1) ? $clog2(KW) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  scan_strobe_t strobe,
  input  logic [KW-1:0] scalarIn,
  output logic         scalarZero,
  output logic         leadIsZero,
  output logic         curBit,
  output logic         idxZero
);

  logic [KW-1:0]    scalarReg;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] leadPos;
  logic             leadZeroReg;

  // leading-one position of the presented scalar
  always_comb begin
    leadPos = '0;
    for (int b = 0; b < KW; b++) begin
      if (scalarIn[b]) leadPos = IDX_W'(b);
    end
  end

  assign scalarZero = (scalarIn == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      scalarReg   <= '0;
      idx         <= '0;
      leadZeroReg <= 1'b0;
    end else if (strobe.capture) begin
      scalarReg   <= scalarIn;
      idx         <= leadPos - IDX_W'(1);
      leadZeroReg <= (leadPos == '0);
    end else if (strobe.step) begin
      idx <= idx - IDX_W'(1);
    end
  end

  assign curBit     = scalarReg[idx];
  assign idxZero    = (idx == '0);
  assign leadIsZero = leadZeroReg;

endmodule

// File: rtl/ladder_ctrl.sv
module ladder_ctrl
  import ladder_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int SLOT_P1 = 1,
  parameter int SLOT_P2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cmdReady,
  input  logic              cmdDone,
  input  logic              scalarZero,
  input  logic              leadIsZero,
  input  logic              curBit,
  input  logic              idxZero,
  output scan_strobe_t      strobe,
  output logic              cmdValid,
  output ladder_op_t        cmdOp,
  output logic [SLOT_W-1:0] cmdSrcA,
  output logic [SLOT_W-1:0] cmdSrcB,
  output logic [SLOT_W-1:0] cmdDst,
  output logic              valid,
  output logic              identity,
  output logic              busy
);

  localparam logic [SLOT_W-1:0] P1 = SLOT_W'(SLOT_P1);
  localparam logic [SLOT_W-1:0] P2 = SLOT_W'(SLOT_P2);

  ladder_phase_t phase;
  logic          inFlight;
  logic          validReg;
  logic          identReg;
  logic          finish;

  assign finish = inFlight && cmdDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      inFlight <= 1'b0;
      validReg <= 1'b0;
      identReg <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (run) begin
        validReg <= scalarZero;
        identReg <= scalarZero;
        if (!scalarZero) phase <= PH_LOAD;
      end
    end else if (!inFlight) begin
      if (cmdReady) inFlight <= 1'b1;
    end else if (finish) begin
      inFlight <= 1'b0;
      unique case (phase)
        PH_LOAD: phase <= leadIsZero ? PH_OUT : PH_SEED;
        PH_SEED: phase <= PH_ADD;
        PH_ADD:  phase <= PH_DBL;
        PH_DBL:  phase <= idxZero ? PH_OUT : PH_ADD;
        PH_OUT: begin
          phase    <= PH_IDLE;
          validReg <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (phase == PH_IDLE) && run && !scalarZero;
    strobe.step    = finish && (phase == PH_DBL) && !idxZero;
  end

  // command fields; only the steering depends on the scalar bit
  always_comb begin
    cmdOp   = OP_LOAD;
    cmdSrcA = '0;
    cmdSrcB = '0;
    cmdDst  = P1;
    unique case (phase)
      PH_SEED: begin
        cmdOp   = OP_DBL;
        cmdSrcA = P1;
        cmdDst  = P2;
      end
      PH_ADD: begin
        cmdOp   = OP_ADD;
        cmdSrcA = P1;
        cmdSrcB = P2;
        cmdDst  = curBit ? P1 : P2;
      end
      PH_DBL: begin
        cmdOp   = OP_DBL;
        cmdSrcA = curBit ? P2 : P1;
        cmdDst  = curBit ? P2 : P1;
      end
      PH_OUT: begin
        cmdOp   = OP_EXPORT;
        cmdSrcA = P1;
        cmdDst  = '0;
      end
      default: ;
    endcase
  end

  assign cmdValid = (phase != PH_IDLE) && !inFlight && cmdReady;
  assign valid    = validReg;
  assign identity = identReg;
  assign busy     = (phase != PH_IDLE);

endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
  import ladder_pkg::*;
#(
  parameter int KW = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [KW-1:0]     scalar,
  input  logic              cmdReady,
  input  logic              cmdDone,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [SLOT_W-1:0] cmdSrcA,
  output logic [SLOT_W-1:0] cmdSrcB,
  output logic [SLOT_W-1:0] cmdDst,
  output logic              valid,
  output logic              identity
);

  scan_strobe_t strobe;
  ladder_op_t   opSel;
  logic         scalarZero;
  logic         leadIsZero;
  logic         curBit;
  logic         idxZero;
  logic         busy;

  ladder_scan #(.KW(KW)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .scalarIn   (scalar),
    .scalarZero (scalarZero),
    .leadIsZero (leadIsZero),
    .curBit     (curBit),
    .idxZero    (idxZero)
  );

  ladder_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cmdReady   (cmdReady),
    .cmdDone    (cmdDone),
    .scalarZero (scalarZero),
    .leadIsZero (leadIsZero),
    .curBit     (curBit),
    .idxZero    (idxZero),
    .strobe     (strobe),
    .cmdValid   (cmdValid),
    .cmdOp      (opSel),
    .cmdSrcA    (cmdSrcA),
    .cmdSrcB    (cmdSrcB),
    .cmdDst     (cmdDst),
    .valid      (valid),
    .identity   (identity),
    .busy       (busy)
  );

  assign cmdOp = opSel;

endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk #(
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cmdReady,
  input logic              cmdDone,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [SLOT_W-1:0] cmdSrcA,
  input logic [SLOT_W-1:0] cmdDst,
  input logic              valid,
  input logic              identity,
  input logic              busy
);

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> cmdReady);

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !run |=> valid);

  // R2
  identity_valid_chk: assert property (@(posedge clk) disable iff (rst)
    identity |-> valid);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !valid);

  // R5
  dbl_inplace_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid && busy && (cmdOp == 2'd2) && (cmdSrcA != 1 || cmdDst != 2) |-> cmdSrcA == cmdDst);

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmdValid);

endmodule

bind ladder_seq ladder_seq_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .cmdReady (cmdReady),
  .cmdDone  (cmdDone),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdSrcA  (cmdSrcA),
  .cmdDst   (cmdDst),
  .valid    (valid),
  .identity (identity),
  .busy     (busy)
);

// File: tb/ladder_seq_tb.sv
module ladder_seq_tb;

  localparam int KW = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic          cmdReady = 1'b0;
  logic          cmdDone = 1'b0;
  logic          cmdValid;
  logic [1:0]    cmdOp;
  logic [SW-1:0] cmdSrcA, cmdSrcB, cmdDst;
  logic          valid, identity;

  int errors = 0;
  int checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  int slots [8];
  int nAdd, nDbl, nCmd, exported;
  bit invOk, steerOk;

  always #4 clk = ~clk;

  ladder_seq #(.KW(KW), .SLOT_W(SW)) u_dut (
    .clk(clk), .rst(rst), .run(run), .scalar(scalar),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB), .cmdDst(cmdDst),
    .valid(valid), .identity(identity)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[3:0]);
  endfunction

  function automatic int leadOf(input int k);
    int l = 0;
    for (int b = 0; b < KW; b++) if (k[b]) l = b;
    return l;
  endfunction

  // one multiplication against an abstract group: a point is its multiple of P
  task automatic doRun(input int k, input bit disturb);
    int cyc;
    int dly;
    bit pending;
    int bitPos;
    int ladderBit;
    nAdd = 0; nDbl = 0; nCmd = 0; exported = -1;
    invOk = 1'b1; steerOk = 1'b1;
    pending = 1'b0; dly = 0;
    bitPos = leadOf(k);
    for (int s = 0; s < 8; s++) slots[s] = -1000;
    @(negedge clk);
    scalar = KW'(k);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    if (k == 0) begin
      // R2: due one cycle after the accepting edge
      check(valid && identity, "R2 zero scalar valid+identity", {valid, identity}, 3);
      check(!cmdValid, "R2 no command for zero", cmdValid, 0);
      return;
    end
    check(!valid, "R10 valid dropped by run", valid, 0);
    cyc = 0;
    while (cyc < 5000) begin
      cmdReady = (rnd() < 12);
      cmdDone = 1'b0;
      if (pending) begin
        if (dly == 0) begin cmdDone = 1'b1; pending = 1'b0; end
        else dly--;
      end
      if (disturb && cyc == 3) begin run = 1'b1; scalar = ~KW'(k); end
      else run = 1'b0;
      #1;
      if (valid) break;
      if (cmdValid) begin
        if (pending || cmdDone) check(1'b0, "R8 command while outstanding", 1, 0);
        nCmd++;
        case (cmdOp)
          2'd0: slots[cmdDst] = 1;
          2'd1: begin
            nAdd++;
            bitPos--;
            ladderBit = (bitPos >= 0) ? k[bitPos] : 0;
            if (cmdSrcA != 1 || cmdSrcB != 2 || cmdDst != (ladderBit ? 1 : 2)) steerOk = 1'b0;
            slots[cmdDst] = slots[cmdSrcA] + slots[cmdSrcB];
          end
          2'd2: begin
            nDbl++;
            slots[cmdDst] = 2 * slots[cmdSrcA];
            if (slots[2] - slots[1] != 1) invOk = 1'b0;
          end
          default: exported = slots[cmdSrcA];
        endcase
        pending = 1'b1;
        dly = rnd() % 3;
      end
      @(negedge clk);
      cyc++;
    end
    run = 1'b0;
    check(valid, "R10 completion raises valid (watchdog)", valid, 1);
    check(!identity, "R2 identity low for nonzero", identity, 0);
    if (k == 1) begin
      check(nCmd == 2 && nAdd == 0 && nDbl == 0, "R3 unit scalar commands", nCmd, 2);
      check(exported == 1, "R3 unit scalar result", exported, 1);
    end else begin
      check(exported == k, "R6 exported k*P", exported, k);
      check(nAdd == leadOf(k), "R7 addition count", nAdd, leadOf(k));
      check(nDbl == leadOf(k) + 1, "R7 doubling count", nDbl, leadOf(k) + 1);
      check(invOk, "R4 ladder invariant after doubling", invOk, 1);
      check(steerOk, "R5 addition slot steering", steerOk, 1);
    end
    if (disturb) check(exported == k, "R9 mid-run run ignored", exported, k);
  endtask

  initial begin
    cmdReady = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!valid && !identity && !cmdValid, "R1 reset outputs", {valid, identity, cmdValid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!valid && !cmdValid, "R1 idle after reset", {valid, cmdValid}, 0);
    for (int k = 0; k < (1 << KW); k++) begin
      doRun(k, (k % 17) == 5);
      if (k % 29 == 3) begin
        repeat (4) @(negedge clk);
        check(valid, "R10 valid held while idle", valid, 1);
      end
    end
    doRun(1, 1'b0);
    doRun(0, 1'b0);
    doRun(200, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule